// File: doc/BRIEF.md
# Interrupt-Capable GPIO Port

This block is one general-purpose I/O channel of between 6 and 16 pins, controlled through a simple word-addressed 32-bit register bus with separate read and write strobes. Each pin can be driven as an output or left as an input, and its synchronized level can be read back. Software picks a direction and an output value for each pin.

Each pin also has an interrupt detector. Software sets it per pin to falling edge, rising edge, both edges, low level or high level. A detected event latches a sticky status bit, but only while that pin's enable bit is set. Software clears status bits by writing ones. A per-pin mask, written through separate set and clear registers, keeps a status bit off the single combined interrupt output.

A two-state soft-reset sequencer has the states RUN and HOLD. In RUN, a write of 1 to bit 0 of the soft-reset register takes the transition to HOLD. In HOLD, every GPIO and interrupt register is held at its reset value and writes to those registers are ignored. A write of 0 to bit 0 takes the transition back to RUN. Any other write leaves the state unchanged.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every readable register reads 0, `pin_out`, `pin_oe` and `irq` are 0, and all pins are inputs.
- R2: OUT (word 0) and DIR (word 2) read back the last value written to their implemented bits, and bits at or above N_PINS read 0. `pin_out` follows OUT. A DIR bit of 1 makes that pin an output on `pin_oe`.
- R3: IN (word 1) is read-only. It returns the pin levels through a two-stage synchronizer: a pin change made between clock edges shows after the second rising edge.
- R4: Each pin's mode is a 3-bit code in a 4-bit field at bit 4*(pin mod 8). MODE_LO (word 6) holds pins 0-7 and MODE_HI (word 7) holds pins 8-15. Only the low 3 bits of each field are stored, and fields of pins that are not implemented read 0.
- R5: The mode codes are 0 falling edge, 1 rising edge, 2 low level, 3 high level and 4 both edges. Codes 5 to 7 detect nothing. Edges compare the current synchronized level with the one from the previous cycle.
- R6: A status bit in STAT (word 8, read-only) is set only while the pin's enable bit in IEN (word 3, read/write) is 1. The bit then stays set until it is cleared.
- R7: Writing SCLR (word 9, reads 0) clears each status bit written as 1, and zero bits have no effect. A detection in the same cycle as the clear wins, so the bit stays set.
- R8: In a level mode, the status bit is set again on every cycle while the level is active, even directly after a clear.
- R9: A 1 written to MSET (word 4) sets that pin's mask bit, a 1 written to MCLR (word 5) clears it, and zero bits leave it unchanged. Both words read the mask. `irq` is 1 exactly when some status bit has its mask bit at 0.
- R10: Writing 1 to bit 0 of SRST (word 10) enters HOLD. In HOLD, all GPIO and interrupt registers read 0 from the next cycle on, and writes to them are ignored. Writing 0 to bit 0 returns to RUN. SRST reads 1 in HOLD and 0 in RUN.
- R11: Writing a mode register never sets a status bit by itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Word address of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; read data is 0 when low |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| pin_in | input | N_PINS | Pin levels from the pads |
| pin_out | output | N_PINS | Output value for each pin |
| pin_oe | output | N_PINS | Output enable for each pin (1 = drive) |
| irq | output | 1 | Combined interrupt request |

## Verification
A status clear and a new detection on the same pin can fall in the same cycle. The bench makes this happen by timing a clear write so that it is sampled on the very edge where a synchronized rising edge is first seen, two cycles after the pin change. A correct design then reads STAT with the bit still set, and a second clear with no new edge must return it to 0. The level-mode case is the continuous form of the same collision: a clear issued while the level is held must leave the bit set.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned BUS_AW       = 4;
    localparam int unsigned BUS_DW       = 32;
    localparam int unsigned MODE_BITS    = 3;
    localparam int unsigned FIELD_W      = 4;
    localparam int unsigned PINS_PER_REG = BUS_DW / FIELD_W;

    // Register word addresses
    localparam logic [BUS_AW-1:0] A_OUT     = 4'd0;
    localparam logic [BUS_AW-1:0] A_IN      = 4'd1;
    localparam logic [BUS_AW-1:0] A_DIR     = 4'd2;
    localparam logic [BUS_AW-1:0] A_IEN     = 4'd3;
    localparam logic [BUS_AW-1:0] A_MSET    = 4'd4;
    localparam logic [BUS_AW-1:0] A_MCLR    = 4'd5;
    localparam logic [BUS_AW-1:0] A_MODE_LO = 4'd6;
    localparam logic [BUS_AW-1:0] A_MODE_HI = 4'd7;
    localparam logic [BUS_AW-1:0] A_STAT    = 4'd8;
    localparam logic [BUS_AW-1:0] A_SCLR    = 4'd9;
    localparam logic [BUS_AW-1:0] A_SRST    = 4'd10;

    typedef enum logic [MODE_BITS-1:0] {
        DET_FALL = 3'd0,
        DET_RISE = 3'd1,
        DET_LOW  = 3'd2,
        DET_HIGH = 3'd3,
        DET_BOTH = 3'd4
    } det_mode_e;

    typedef enum logic [0:0] {
        SR_RUN  = 1'b0,
        SR_HOLD = 1'b1
    } srst_state_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] hist_o
);

    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '0;
                else        chain_q[s] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '0;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    end

    // Level seen one cycle earlier, for edge comparison
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_o <= '0;
        else        hist_o <= chain_q[STAGES-1];
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
    import gpio_irq_pkg::*;
(
    input  logic [MODE_BITS-1:0] mode_code,
    input  logic                 cur,
    input  logic                 prev,
    input  logic                 enable,
    output logic                 hit
);

    det_mode_e mode;
    logic      raw;

    assign mode = det_mode_e'(mode_code);

    always_comb begin
        unique case (mode)
            DET_FALL: raw = prev & ~cur;
            DET_RISE: raw = ~prev & cur;
            DET_LOW:  raw = ~cur;
            DET_HIGH: raw = cur;
            DET_BOTH: raw = prev ^ cur;
            default:  raw = 1'b0;
        endcase
    end

    assign hit = enable & raw;

endmodule

// File: rtl/gpio_srst_fsm.sv
module gpio_srst_fsm
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sr_write,
    input  logic sr_bit,
    output logic hold
);

    srst_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SR_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SR_RUN:  if (sr_write &&  sr_bit) state_d = SR_HOLD;
            SR_HOLD: if (sr_write && !sr_bit) state_d = SR_RUN;
            default: state_d = SR_RUN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            SR_HOLD: hold = 1'b1;
            default: hold = 1'b0;
        endcase
    end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N_PINS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_DW-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe,
    output logic              irq
);

    localparam int unsigned PAD_W = BUS_DW - N_PINS;

    logic              sr_hold;
    logic              wr_ok;
    logic [N_PINS-1:0] out_q, dir_q, ien_q, mask_q, stat_q;
    logic [N_PINS-1:0] pin_sync, pin_hist, hit;
    logic [MODE_BITS-1:0] mode_q [N_PINS];
    logic [BUS_DW-1:0] mode_lo_rd, mode_hi_rd;

    // Soft-reset sequencer
    gpio_srst_fsm u_srst (
        .clk      (clk),
        .rst_n    (rst_n),
        .sr_write (bus_wr && bus_addr == A_SRST),
        .sr_bit   (bus_wdata[0]),
        .hold     (sr_hold)
    );

    assign wr_ok = bus_wr && !sr_hold;

    // Input synchronizer with one cycle of history
    gpio_in_sync #(.WIDTH(N_PINS), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (pin_sync),
        .hist_o  (pin_hist)
    );

    // Plain read/write registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            dir_q <= '0;
            ien_q <= '0;
        end else if (sr_hold) begin
            out_q <= '0;
            dir_q <= '0;
            ien_q <= '0;
        end else if (wr_ok) begin
            if (bus_addr == A_OUT) out_q <= bus_wdata[N_PINS-1:0];
            if (bus_addr == A_DIR) dir_q <= bus_wdata[N_PINS-1:0];
            if (bus_addr == A_IEN) ien_q <= bus_wdata[N_PINS-1:0];
        end
    end

    // Mask: separate set and clear words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        mask_q <= '0;
        else if (sr_hold)  mask_q <= '0;
        else if (wr_ok && bus_addr == A_MSET) mask_q <= mask_q |  bus_wdata[N_PINS-1:0];
        else if (wr_ok && bus_addr == A_MCLR) mask_q <= mask_q & ~bus_wdata[N_PINS-1:0];
    end

    // Per-pin mode fields and detectors
    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        localparam int unsigned POS = FIELD_W * (i % PINS_PER_REG);
        localparam logic [BUS_AW-1:0] MADDR = (i < PINS_PER_REG) ? A_MODE_LO : A_MODE_HI;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       mode_q[i] <= '0;
            else if (sr_hold) mode_q[i] <= '0;
            else if (wr_ok && bus_addr == MADDR) mode_q[i] <= bus_wdata[POS +: MODE_BITS];
        end

        gpio_pin_detect u_det (
            .mode_code (mode_q[i]),
            .cur       (pin_sync[i]),
            .prev      (pin_hist[i]),
            .enable    (ien_q[i]),
            .hit       (hit[i])
        );
    end

    // Sticky status: a detection wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       stat_q <= '0;
        else if (sr_hold) stat_q <= '0;
        else if (wr_ok && bus_addr == A_SCLR) stat_q <= (stat_q & ~bus_wdata[N_PINS-1:0]) | hit;
        else              stat_q <= stat_q | hit;
    end

    // Mode read images
    always_comb begin
        mode_lo_rd = '0;
        mode_hi_rd = '0;
        for (int i = 0; i < int'(N_PINS); i++) begin
            if (i < int'(PINS_PER_REG))
                mode_lo_rd[FIELD_W*(i % PINS_PER_REG) +: MODE_BITS] = mode_q[i];
            else
                mode_hi_rd[FIELD_W*(i % PINS_PER_REG) +: MODE_BITS] = mode_q[i];
        end
    end

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                A_OUT:     bus_rdata = {{PAD_W{1'b0}}, out_q};
                A_IN:      bus_rdata = {{PAD_W{1'b0}}, pin_sync};
                A_DIR:     bus_rdata = {{PAD_W{1'b0}}, dir_q};
                A_IEN:     bus_rdata = {{PAD_W{1'b0}}, ien_q};
                A_MSET,
                A_MCLR:    bus_rdata = {{PAD_W{1'b0}}, mask_q};
                A_MODE_LO: bus_rdata = mode_lo_rd;
                A_MODE_HI: bus_rdata = mode_hi_rd;
                A_STAT:    bus_rdata = {{PAD_W{1'b0}}, stat_q};
                A_SRST:    bus_rdata = {{(BUS_DW-1){1'b0}}, sr_hold};
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
    assign irq     = |(stat_q & ~mask_q);

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N_PINS = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BUS_AW-1:0] bus_addr,
    input logic              bus_wr,
    input logic [BUS_DW-1:0] bus_wdata,
    input logic [N_PINS-1:0] pin_out,
    input logic [N_PINS-1:0] pin_oe,
    input logic              irq,
    input logic [N_PINS-1:0] stat_q,
    input logic [N_PINS-1:0] ien_q,
    input logic [N_PINS-1:0] mask_q,
    input logic              sr_hold
);

    // R6: a status bit only rises when its pin was enabled
    a_r6_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((stat_q & ~$past(stat_q) & ~$past(ien_q)) == '0));

    // R7: a status bit only falls after a clear write or during soft reset
    a_r7_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(stat_q) & ~stat_q) != '0) |->
            ($past(bus_wr && bus_addr == A_SCLR) || $past(sr_hold)));

    // R2: a direction write appears on the output enables
    a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !sr_hold && bus_addr == A_DIR) |=> (pin_oe == $past(bus_wdata[N_PINS-1:0])));

    // R10: outputs stay quiet while soft reset is held
    a_r10_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_hold && $past(sr_hold)) |-> (pin_out == '0 && pin_oe == '0 && !irq));

    // R9: with every pin masked the interrupt line is low
    a_r9_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> !irq);

endmodule

bind gpio_irq_port gpio_irq_port_chk #(.N_PINS(N_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .stat_q    (stat_q),
    .ien_q     (ien_q),
    .mask_q    (mask_q),
    .sr_hold   (sr_hold)
);

// File: tb/test_gpio_irq_port.sv
`timescale 1ns/1ps
module test_gpio_irq_port;

    localparam int NP = 10;
    localparam logic [31:0] PMASK = (32'd1 << NP) - 1;
    localparam logic [3:0] A_OUT = 0, A_IN = 1, A_DIR = 2, A_IEN = 3, A_MSET = 4,
                           A_MCLR = 5, A_MLO = 6, A_MHI = 7, A_STAT = 8,
                           A_SCLR = 9, A_SRST = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    baddr = '0;
    logic          bwr = 1'b0;
    logic [31:0]   bwdata = '0;
    logic          brd = 1'b0;
    logic [31:0]   brdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic          irq;

    int nchk = 0;
    int nerr = 0;
    int sh [NP];

    always #2 clk = ~clk;

    gpio_irq_port #(.N_PINS(NP)) i_gpio_irq_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(baddr), .bus_wr(bwr),
        .bus_wdata(bwdata), .bus_rd(brd), .bus_rdata(brdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        baddr = a; bwdata = d; bwr = 1'b1;
        @(negedge clk);
        bwr = 1'b0; bwdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        baddr = a; brd = 1'b1;
        #0.5;
        d = brdata;
        brd = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    function automatic logic [31:0] mode_word(input bit hi);
        logic [31:0] w = '0;
        for (int i = 0; i < NP; i++)
            if ((i >= 8) == hi) w[4*(i%8) +: 3] = sh[i][2:0];
        return w;
    endfunction

    task automatic set_mode(input int p, input int m);
        sh[p] = m;
        wr(A_MLO, mode_word(1'b0));
        wr(A_MHI, mode_word(1'b1));
    endtask

    function automatic bit exp_hit(input int m, input bit a, input bit b);
        case (m)
            0: return a & !b;
            1: return !a & b;
            2: return !a | !b;
            3: return a | b;
            4: return a ^ b;
            default: return 1'b0;
        endcase
    endfunction

    // Fields valid for NP pins, low 3 bits each
    function automatic logic [31:0] field_mask(input bit hi);
        logic [31:0] w = '0;
        for (int i = 0; i < NP; i++)
            if ((i >= 8) == hi) w[4*(i%8) +: 3] = 3'b111;
        return w;
    endfunction

    initial begin
        logic [31:0] v;
        for (int i = 0; i < NP; i++) sh[i] = 0;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1: reset state
        for (int a = 0; a <= 10; a++) rd_chk("R1 register after reset", 4'(a), 32'h0);
        chk("R1 pin_out", 32'(pin_out), 0);
        chk("R1 pin_oe", 32'(pin_oe), 0);
        chk("R1 irq", 32'(irq), 0);

        // R2: output and direction
        wr(A_OUT, 32'hFFFF_FFFF);
        rd_chk("R2 OUT upper bits", A_OUT, PMASK);
        chk("R2 pin_out", 32'(pin_out), PMASK);
        wr(A_OUT, 32'h0000_0135);
        rd_chk("R2 OUT readback", A_OUT, 32'h135);
        chk("R2 pin_out value", 32'(pin_out), 32'h135);
        wr(A_DIR, 32'hFFFF_F2A5);
        rd_chk("R2 DIR upper bits zero", A_DIR, 32'hFFFF_F2A5 & PMASK);
        chk("R2 pin_oe", 32'(pin_oe), 32'hFFFF_F2A5 & PMASK);
        wr(A_DIR, 32'h0);
        chk("R2 pin_oe cleared", 32'(pin_oe), 0);

        // R3: input synchronizer latency
        pin_in = 10'h155;
        tick(1);
        rd_chk("R3 IN after one edge", A_IN, 32'h0);
        tick(1);
        rd_chk("R3 IN after two edges", A_IN, 32'h155);
        pin_in = '0;
        tick(2);
        rd_chk("R3 IN back low", A_IN, 32'h0);

        // R4: mode field layout
        wr(A_MLO, 32'hFFFF_FFFF);
        rd_chk("R4 MODE_LO low 3 bits", A_MLO, field_mask(1'b0));
        wr(A_MHI, 32'hFFFF_FFFF);
        rd_chk("R4 MODE_HI implemented fields", A_MHI, field_mask(1'b1));
        wr(A_MLO, 32'h8ABC_DEF9);
        rd_chk("R4 MODE_LO pattern", A_MLO, 32'h8ABC_DEF9 & field_mask(1'b0));
        wr(A_MLO, 32'h0);
        wr(A_MHI, 32'h0);
        rd_chk("R4 MODE_HI cleared", A_MHI, 32'h0);
        chk("R11 no status from mode writes", 32'(irq), 0);

        // R5: sweep of pins, mode codes and transition directions
        for (int p = 0; p < NP; p++) begin
            for (int m = 0; m < 8; m++) begin
                for (int v0 = 0; v0 < 2; v0++) begin
                    bit e;
                    pin_in = (v0 != 0) ? NP'(1 << p) : '0;
                    wr(A_IEN, 32'h0);
                    set_mode(p, m);
                    tick(3);
                    wr(A_IEN, 32'(1) << p);
                    wr(A_SCLR, 32'hFFFF_FFFF);
                    tick(1);
                    pin_in = pin_in ^ NP'(1 << p);
                    tick(4);
                    e = exp_hit(m, v0 != 0, v0 == 0);
                    rd(A_STAT, v);
                    chk($sformatf("R5 pin %0d mode %0d start %0d status", p, m, v0),
                        v, e ? (32'(1) << p) : 32'h0);
                    chk($sformatf("R5 pin %0d mode %0d start %0d irq", p, m, v0),
                        32'(irq), 32'(e));
                end
            end
            sh[p] = 0;
        end
        pin_in = '0;
        wr(A_IEN, 32'h0);
        wr(A_MLO, 32'h0);
        wr(A_MHI, 32'h0);
        tick(3);
        wr(A_SCLR, 32'hFFFF_FFFF);
        rd_chk("R5 sweep cleanup", A_STAT, 32'h0);

        // R7: clear and rising edge in the same cycle
        set_mode(3, 1);
        wr(A_IEN, 32'h8);
        pin_in[3] = 1'b1;
        tick(2);
        wr(A_SCLR, 32'h8);
        rd_chk("R7 detection wins over clear", A_STAT, 32'h8);
        wr(A_SCLR, 32'h8);
        rd_chk("R7 clear without event", A_STAT, 32'h0);

        // R11: mode writes with a steady high pin set nothing
        set_mode(3, 0);
        set_mode(3, 4);
        set_mode(3, 1);
        set_mode(3, 0);
        tick(3);
        rd_chk("R11 mode writes set no status", A_STAT, 32'h0);
        wr(A_IEN, 32'h0);

        // R6: enable gating and stickiness
        set_mode(5, 1);
        pin_in[5] = 1'b1;
        tick(4);
        rd_chk("R6 disabled pin latches nothing", A_STAT, 32'h0);
        wr(A_IEN, 32'h20);
        tick(3);
        rd_chk("R6 enabling alone latches nothing", A_STAT, 32'h0);
        pin_in[5] = 1'b0;
        tick(3);
        pin_in[5] = 1'b1;
        tick(4);
        rd_chk("R6 enabled rise latches", A_STAT, 32'h20);
        pin_in[5] = 1'b0;
        tick(10);
        rd_chk("R6 status is sticky", A_STAT, 32'h20);

        // R7: zero bits of a clear have no effect
        wr(A_SCLR, 32'hFFFF_FFDF);
        rd_chk("R7 zero bits keep status", A_STAT, 32'h20);

        // R9: masking
        chk("R9 irq unmasked", 32'(irq), 1);
        wr(A_MSET, 32'h20);
        chk("R9 irq masked", 32'(irq), 0);
        rd_chk("R9 MSET reads mask", A_MSET, 32'h20);
        rd_chk("R9 MCLR reads mask", A_MCLR, 32'h20);
        wr(A_MCLR, 32'h0);
        chk("R9 zero clear keeps mask", 32'(irq), 0);
        wr(A_MSET, 32'h4);
        rd_chk("R9 set accumulates", A_MSET, 32'h24);
        wr(A_MCLR, 32'h20);
        chk("R9 irq after unmask", 32'(irq), 1);
        rd_chk("R9 mask after clear", A_MSET, 32'h4);

        // R8: level mode re-sets after a clear
        set_mode(7, 3);
        wr(A_IEN, 32'h80);
        pin_in[7] = 1'b1;
        tick(4);
        wr(A_SCLR, 32'hFFFF_FFFF);
        rd_chk("R8 level status set again", A_STAT, 32'h80);
        tick(2);
        wr(A_SCLR, 32'h80);
        rd_chk("R8 level status after second clear", A_STAT, 32'h80);

        // R10: soft reset hold and release
        wr(A_OUT, 32'h3FF);
        wr(A_DIR, 32'h0F0);
        wr(A_SRST, 32'h1);
        tick(1);
        rd_chk("R10 SRST reads held", A_SRST, 32'h1);
        rd_chk("R10 OUT cleared", A_OUT, 32'h0);
        rd_chk("R10 DIR cleared", A_DIR, 32'h0);
        rd_chk("R10 IEN cleared", A_IEN, 32'h0);
        rd_chk("R10 mask cleared", A_MSET, 32'h0);
        rd_chk("R10 mode cleared", A_MLO, 32'h0);
        rd_chk("R10 status cleared", A_STAT, 32'h0);
        chk("R10 irq low", 32'(irq), 0);
        chk("R10 pin_oe low", 32'(pin_oe), 0);
        wr(A_OUT, 32'h55);
        rd_chk("R10 write ignored in hold", A_OUT, 32'h0);
        wr(A_SRST, 32'h0);
        rd_chk("R10 SRST released", A_SRST, 32'h0);
        rd_chk("R10 OUT still reset", A_OUT, 32'h0);
        wr(A_OUT, 32'h55);
        rd_chk("R10 writes work after release", A_OUT, 32'h55);
        tick(3);
        rd_chk("R10 status stays clear", A_STAT, 32'h0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #(200000 * 4);
        nerr++;
        nchk++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule